// File: doc/BRIEF.md
# Idle-Locked Serial Descrambler

This block recovers plain NRZ data from a serial stream that a far-end transmitter has scrambled. The transmitter adds its data, modulo two, to a key stream from an 11-bit linear feedback shift register. One scrambled bit arrives on each clock, and one descrambled bit leaves on each clock. The receiver does not know the transmitter's register state. It recovers that state from the line itself. Between frames the transmitter sends IDLE, which is all ones before scrambling, so each received bit is then the inverse of the key bit. During acquisition the block therefore loads its own register with the inverted received bits.

Lock is declared only after a long unbroken run of descrambled ones. Once locked, the register runs on its own. A hold timer then watches the line and needs a fresh run of idle in each window. If the window passes without one, the block raises a one-cycle loss strobe, clears its state and starts acquisition again. A bypass input sends the received bits straight to the output.

Top module: `idle_lock_descrambler`

## Requirements
- R1: The key bit is the XOR of register bits 10 and 8 (the polynomial x^11 + x^9 + 1). In key-stream terms, k(t) = k(t-11) XOR k(t-9). The descrambled bit is rx_bit XOR the key bit.
- R2: While not in sync, the register shifts in the inverted received bit, in_sync is 0, and dout_valid is 0 when bypass is 0.
- R3: in_sync rises at the clock edge that samples the 60th consecutive descrambled one (LOCK_ONES).
- R4: Any descrambled zero clears the count of consecutive ones. Only an unbroken run counts toward lock or toward a hold refresh.
- R5: While in sync, the register shifts in its own key bit. dout carries the descrambled bit one clock after rx_bit, with dout_valid at 1.
- R6: The hold timer spans HOLD_WIN clocks, measured from lock or from the last refresh. A refresh occurs at the edge that samples the 58th consecutive descrambled one (HOLD_ONES) while in sync, and the run count then starts again from zero.
- R7: Expiry occurs at the edge HOLD_WIN clocks after lock or the last refresh, when that edge is not itself a refresh. At expiry in_sync falls, sync_lost is 1 for exactly one clock in that same cycle, the register clears and acquisition restarts.
- R8: With bypass at 1, dout equals the rx_bit sampled at the previous edge and dout_valid is 1.
- R9: After reset, dout, dout_valid, in_sync and sync_lost are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Pass received bits through unchanged |
| rx_bit | input | 1 | Scrambled serial input bit |
| dout | output | 1 | Descrambled (or bypassed) bit, registered |
| dout_valid | output | 1 | dout carries locked or bypassed data |
| in_sync | output | 1 | Key stream locked |
| sync_lost | output | 1 | One-cycle strobe on hold-timer expiry |

## Verification
A wrong key register shows within about eleven bits: descrambled idle stops being all ones, so lock never comes, or data after lock comes out wrong bit by bit. The bench uses a starting key sequence that makes the lock edge exact, at bit 71, and it checks data bytes one bit after another. Faults in the run counter or the timer show only at the window edge. The bench therefore measures the exact clock distance from lock, and from the last refresh, to the loss strobe. It also checks that broken runs neither lock nor refresh.

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler #(
  parameter int LFSR_W    = 11,
  parameter int TAP_B     = 9,
  parameter int LOCK_ONES = 60,
  parameter int HOLD_ONES = 58,
  parameter int HOLD_WIN  = 90250,
  localparam int RUN_W = $clog2(LOCK_ONES + 1),
  localparam int TMR_W = $clog2(HOLD_WIN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic rx_bit,
  output logic dout,
  output logic dout_valid,
  output logic in_sync,
  output logic sync_lost
);

  logic [LFSR_W-1:0] lfsr;
  logic [RUN_W-1:0]  run_q;
  logic [TMR_W-1:0]  tmr_q;
  logic key, plain_bit, lock_hit, refresh_hit, expire;

  assign key         = lfsr[LFSR_W-1] ^ lfsr[TAP_B-1];
  assign plain_bit   = rx_bit ^ key;
  assign lock_hit    = !in_sync && plain_bit && (run_q == RUN_W'(LOCK_ONES - 1));
  assign refresh_hit = in_sync && plain_bit && (run_q == RUN_W'(HOLD_ONES - 1));
  assign expire      = in_sync && !refresh_hit && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr       <= '0;
      run_q      <= '0;
      tmr_q      <= '0;
      in_sync    <= 1'b0;
      sync_lost  <= 1'b0;
      dout       <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      sync_lost  <= expire;
      dout       <= bypass ? rx_bit : plain_bit;
      dout_valid <= bypass | in_sync;
      if (expire) begin
        in_sync <= 1'b0;
        lfsr    <= '0;
        run_q   <= '0;
        tmr_q   <= '0;
      end else begin
        lfsr <= {lfsr[LFSR_W-2:0], in_sync ? key : ~rx_bit};
        if (!plain_bit || lock_hit || refresh_hit) run_q <= '0;
        else                                       run_q <= run_q + 1'b1;
        if (lock_hit) begin
          in_sync <= 1'b1;
          tmr_q   <= TMR_W'(HOLD_WIN - 1);
        end else if (refresh_hit) begin
          tmr_q   <= TMR_W'(HOLD_WIN - 1);
        end else if (in_sync) begin
          tmr_q   <= tmr_q - 1'b1;
        end
      end
    end
  end

  a_r3_lock_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(plain_bit));
  a_r7_fall_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> sync_lost);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !sync_lost);
  a_r7_strobe_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !in_sync);
  a_r8_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (dout == $past(rx_bit)) && dout_valid);
  a_r2_acq_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !bypass) |=> !dout_valid);
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (tmr_q <= TMR_W'(HOLD_WIN - 1)));

endmodule

// File: tb/tb_idle_lock_descrambler.sv
module tb_idle_lock_descrambler;
  localparam int CLK_P = 10;
  localparam int HOLD  = 200;
  localparam logic [10:0] PRE = 11'b00111111111;
  localparam logic [7:0] DATA_VEC [8] =
    '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h7E, 8'h0F, 8'hC3};

  logic clk = 1'b0, rst_n = 1'b0, bypass = 1'b0, rx_bit = 1'b0;
  logic dout, dout_valid, in_sync, sync_lost;

  idle_lock_descrambler #(.HOLD_WIN(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .rx_bit(rx_bit),
    .dout(dout), .dout_valid(dout_valid), .in_sync(in_sync), .sync_lost(sync_lost));

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0, kidx = 0;
  int lock_cyc = -1, lost_cyc = -1, lost_cnt = 0, ref_cyc = -1;
  logic prev_sync = 1'b0;
  logic [10:0] kh = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic next_key();
    logic k;
    if (kidx < 11) k = PRE[kidx];
    else           k = kh[10] ^ kh[8];
    kh = {kh[9:0], k};
    kidx++;
    return k;
  endfunction

  task automatic step(input logic r);
    rx_bit = r;
    @(posedge clk); #1;
    cyc++;
    if (in_sync && !prev_sync) lock_cyc = cyc;
    if (sync_lost) begin lost_cnt++; lost_cyc = cyc; end
    prev_sync = in_sync;
  endtask

  task automatic send(input logic data, input bit check_out, input string req);
    logic k;
    k = next_key();
    step(data ^ k);
    if (check_out) chk(dout == data && dout_valid, req, {dout_valid, dout}, {1'b1, data});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int base, lc;
    bit bad;
    repeat (3) @(posedge clk);
    #1;
    chk({dout, dout_valid, in_sync, sync_lost} == 4'b0, "R9 reset",
        {dout, dout_valid, in_sync, sync_lost}, 0);
    rst_n = 1'b1;

    bad = 0;
    for (int i = 0; i < 70; i++) begin
      send(1'b1, 0, "");
      if (in_sync || dout_valid) bad = 1;
    end
    chk(!bad, "R2 acquisition invalid", bad, 0);
    chk(!in_sync, "R3 not before 60th one", in_sync, 0);
    send(1'b1, 0, "");
    chk(in_sync, "R3 lock on 60th one", in_sync, 1);

    for (int v = 0; v < 8; v++)
      for (int b = 7; b >= 0; b--)
        send(DATA_VEC[v][b], 1, "R1 R5 descrambled data");

    for (int i = 0; i < 400 && lost_cnt == 0; i++) send(logic'(i % 2), 0, "");
    chk(lost_cyc - lock_cyc == HOLD, "R7 expiry after lock", lost_cyc - lock_cyc, HOLD);
    chk(!in_sync, "R7 unlocked at strobe", in_sync, 0);
    send(1'b1, 0, "");
    chk(!sync_lost && lost_cnt == 1, "R7 single strobe", lost_cnt, 1);

    for (int i = 0; i < 51; i++) send(1'b1, 0, "");
    send(1'b0, 0, "");
    for (int i = 0; i < 40; i++) send(1'b1, 0, "");
    chk(!in_sync, "R4 broken run no lock", in_sync, 0);
    for (int i = 0; i < 100; i++) send(1'b1, 0, "");
    chk(in_sync, "R3 relock", in_sync, 1);

    lc = lost_cnt;
    for (int blk = 0; blk < 4; blk++) begin
      for (int i = 0; i < 100; i++) send(logic'((i % 2) == 0), 0, "");
      for (int i = 0; i < 58; i++) send(1'b1, 0, "");
      ref_cyc = cyc;
    end
    chk(in_sync && lost_cnt == lc, "R6 refresh holds sync", lost_cnt, lc);

    base = lost_cnt;
    for (int i = 0; i < 400 && lost_cnt == base; i++) send(logic'((i % 58) != 57), 0, "");
    chk(lost_cyc - ref_cyc == HOLD, "R6 R4 window after refresh", lost_cyc - ref_cyc, HOLD);

    bypass = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(DATA_VEC[3][i]);
      chk(dout == DATA_VEC[3][i] && dout_valid, "R8 bypass", {dout_valid, dout},
          {1'b1, DATA_VEC[3][i]});
    end

    rst_n = 1'b0;
    step(1'b1);
    chk({dout, dout_valid, in_sync, sync_lost} == 4'b0, "R9 reset mid-run",
        {dout, dout_valid, in_sync, sync_lost}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule